// File: doc/BRIEF.md
# CAN Bit Timer

This block turns the controller clock into CAN time quanta and walks each nominal bit through its three segments. The segments are a one-quantum synchronisation slot, a first phase that holds propagation delay plus phase 1, and a second phase. The quantum length comes from a 10-bit divider. Its upper four bits arrive on a separate extension field, which sits above the six-bit low field. The phase lengths and the resynchronisation jump width arrive as small configuration fields. Each of these fields carries the wanted count minus one.

Three outputs mark the bit. The block pulses a strobe as each bit opens. It pulses a second strobe at the sample point, which is the close of the first phase, and at that moment it captures the synchronised receive line. It watches the receive line for recessive-to-dominant transitions. While the bus is idle such a transition restarts the bit (hard synchronisation). During traffic the transition stretches the first phase or trims the second, within the jump width, and this happens once per bit at most. A combinational flag reports a programmed bit length outside the legal quantum range.

Top module: `can_bit_timer`

## Requirements
- R1: One quantum lasts ({pscl_hi_i, pscl_lo_i} + 1) clock cycles, with pscl_hi_i forming bits 9..6 of the divider value.
- R2: With no receive activity, bit_start_o pulses for one cycle every (ph1_len_i + ph2_len_i + 3) quanta.
- R3: sample_o pulses for one cycle (ph1_len_i + 2) quanta after bit_start_o, plus any phase-1 extension. In that same cycle rx_bit_o takes the synchronised rx_i level.
- R4: cfg_err_o is high exactly when ph1_len_i + ph2_len_i + 3 is below 8 or above 25.
- R5: With bus_idle_i high, a falling edge on rx_i makes bit_start_o pulse on the third rising clock edge after the change (two synchroniser stages, then edge detection). A bit of nominal length follows.
- R6: With bus_idle_i low, a falling edge detected in quantum q (0-based) of phase 1 lengthens the bit by min(q + 1, jump_w_i + 1) quanta.
- R7: With bus_idle_i low, a falling edge detected in quantum q of phase 2, whose nominal length is L2 = ph2_len_i + 1, cuts phase 2 to max(q + 1, L2 - min(L2 - q, jump_w_i + 1)) quanta.
- R8: A falling edge detected in the synchronisation quantum leaves the bit length unchanged.
- R9: Rising edges on rx_i change neither the bit length nor the sample position.
- R10: Only the first falling edge in a bit adjusts it. A second falling edge in the same bit has no effect.
- R11: After reset, bit_start_o and sample_o are low and rx_bit_o is 1 (recessive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pscl_lo_i | input | 6 | Divider low field (value minus one) |
| pscl_hi_i | input | 4 | Divider extension, bits 9..6 |
| ph1_len_i | input | 4 | Propagation plus phase-1 length minus one |
| ph2_len_i | input | 3 | Phase-2 length minus one |
| jump_w_i | input | 2 | Resynchronisation jump width minus one |
| bus_idle_i | input | 1 | High while no frame is in progress |
| rx_i | input | 1 | Receive line, 1 = recessive |
| bit_start_o | output | 1 | Pulse as each bit begins |
| sample_o | output | 1 | Pulse at the sample point |
| rx_bit_o | output | 1 | Receive level captured at the last sample point |
| cfg_err_o | output | 1 | Bit length outside 8..25 quanta |

## Verification
The bench sweeps every edge position across whole bits for several phase lengths and all four jump widths. This covers the clamp boundary where the phase error equals the jump width. A design that mixed up the two clamps, or that allowed a cut to end phase 2 before the current quantum, would produce bit periods that are off by whole quanta. It also covers an edge in the final phase-2 quantum and an edge in the synchronisation slot, where an off-by-one would drift the sample point. Further tests place a second edge inside one bit, drive rising edges only, and use a divider value that needs the extension field. These expose a timer that adjusts twice, reacts to the wrong polarity, or drops the upper divider bits.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
   typedef enum logic [1:0] {
      SEG_SYNC = 2'd0,
      SEG_PH1  = 2'd1,
      SEG_PH2  = 2'd2
   } seg_t;
endpackage

// File: rtl/can_tq_div.sv
module can_tq_div #(
   parameter int DIV_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [DIV_W-1:0] div,
   output logic             tq_stb
);
   logic [DIV_W-1:0] cnt;

   // wrap at or above the limit so a lowered divider cannot strand the count
   assign tq_stb = (cnt >= div) && !restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (restart || tq_stb)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

   // R1
   tq_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tq_stb |=> (cnt == '0));
endmodule

// File: rtl/can_rx_sync.sv
module can_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx,
   output logic rx_s,
   output logic fall
);
   logic [STAGES-1:0] chain;
   logic              prev;

   genvar i;
   generate
      for (i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= rx;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b1;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b1;
      else        prev <= rx_s;
   end

   assign rx_s = chain[STAGES-1];
   assign fall = prev & ~rx_s;
endmodule

// File: rtl/can_bit_fsm.sv
module can_bit_fsm
   import can_bt_pkg::*;
#(
   parameter int TS1_W = 4,
   parameter int TS2_W = 3,
   parameter int SJW_W = 2,
   parameter int CW    = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tq_stb,
   input  logic             hard,
   input  logic             fall,
   input  logic             idle,
   input  logic             rx_s,
   input  logic [TS1_W-1:0] ph1_len,
   input  logic [TS2_W-1:0] ph2_len,
   input  logic [SJW_W-1:0] jump_w,
   output logic             start_q,
   output logic             samp_q,
   output logic             rx_bit
);
   seg_t          seg;
   logic [CW-1:0] qc, lim1, lim2, lim1_nxt, lim2_nxt;
   logic [CW-1:0] jw, ext1, e2, s2;
   logic          rs_done, adj_ok, enter_sync;
   logic [1:0]    adj_cnt;

   assign jw     = CW'(jump_w) + 1'b1;
   assign ext1   = ((qc + 1'b1) < jw) ? (qc + 1'b1) : jw;
   assign e2     = lim2 - qc + 1'b1;
   assign s2     = (e2 < jw) ? e2 : jw;
   assign adj_ok = fall && !idle && !rs_done && !hard;

   always_comb begin
      lim1_nxt = lim1;
      lim2_nxt = lim2;
      if (adj_ok && seg == SEG_PH1)
         lim1_nxt = lim1 + ext1;
      if (adj_ok && seg == SEG_PH2)
         lim2_nxt = (lim2 >= (s2 + qc)) ? (lim2 - s2) : qc;
   end

   assign enter_sync = hard || (tq_stb && seg == SEG_PH2 && qc == lim2_nxt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg     <= SEG_SYNC;
         qc      <= '0;
         lim1    <= '0;
         lim2    <= '0;
         rs_done <= 1'b0;
         start_q <= 1'b0;
         samp_q  <= 1'b0;
         rx_bit  <= 1'b1;
      end else begin
         start_q <= 1'b0;
         samp_q  <= 1'b0;
         if (hard) begin
            seg     <= SEG_SYNC;
            qc      <= '0;
            rs_done <= 1'b0;
            start_q <= 1'b1;
         end else begin
            lim1 <= lim1_nxt;
            lim2 <= lim2_nxt;
            if (adj_ok)
               rs_done <= 1'b1;
            if (tq_stb) begin
               unique case (seg)
                  SEG_SYNC: begin
                     seg  <= SEG_PH1;
                     qc   <= '0;
                     lim1 <= CW'(ph1_len);
                     lim2 <= CW'(ph2_len);
                  end
                  SEG_PH1: begin
                     if (qc == lim1_nxt) begin
                        seg    <= SEG_PH2;
                        qc     <= '0;
                        samp_q <= 1'b1;
                        rx_bit <= rx_s;
                     end else begin
                        qc <= qc + 1'b1;
                     end
                  end
                  SEG_PH2: begin
                     if (qc == lim2_nxt) begin
                        seg     <= SEG_SYNC;
                        qc      <= '0;
                        start_q <= 1'b1;
                        rs_done <= 1'b0;
                     end else begin
                        qc <= qc + 1'b1;
                     end
                  end
                  default: seg <= SEG_SYNC;
               endcase
            end
         end
      end
   end

   // adjustment count per bit, kept for the checker below
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         adj_cnt <= '0;
      else if (enter_sync)
         adj_cnt <= '0;
      else if (adj_ok && adj_cnt != 2'd3)
         adj_cnt <= adj_cnt + 1'b1;
   end

   // R3
   samp_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      samp_q |-> (rx_bit == $past(rx_s)));
   // R2
   start_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |-> (seg == SEG_SYNC));
   // R6
   ph1_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seg == SEG_PH1) |-> (lim1 <= CW'(ph1_len) + jw));
   // R7
   ph2_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seg == SEG_PH2) |-> (qc <= lim2));
   // R10
   one_adj_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adj_cnt <= 2'd1);
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
   parameter int LO_W     = 6,
   parameter int HI_W     = 4,
   parameter int TS1_W    = 4,
   parameter int TS2_W    = 3,
   parameter int SJW_W    = 2,
   parameter int STAGES   = 2,
   parameter int MIN_TQ   = 8,
   parameter int MAX_TQ   = 25
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LO_W-1:0]  pscl_lo_i,
   input  logic [HI_W-1:0]  pscl_hi_i,
   input  logic [TS1_W-1:0] ph1_len_i,
   input  logic [TS2_W-1:0] ph2_len_i,
   input  logic [SJW_W-1:0] jump_w_i,
   input  logic             bus_idle_i,
   input  logic             rx_i,
   output logic             bit_start_o,
   output logic             sample_o,
   output logic             rx_bit_o,
   output logic             cfg_err_o
);
   localparam int DIV_W = LO_W + HI_W;
   localparam int CW    = ((TS1_W > TS2_W) ? TS1_W : TS2_W) + 2;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("can_bit_timer: STAGES must be at least 2");
      end
      if (MIN_TQ > MAX_TQ) begin : g_bad_range
         $error("can_bit_timer: MIN_TQ exceeds MAX_TQ");
      end
      if (SJW_W > TS1_W) begin : g_bad_sjw
         $error("can_bit_timer: SJW_W wider than TS1_W");
      end
   endgenerate

   logic [DIV_W-1:0] div;
   logic             tq_stb, rx_s, fall, hard;
   logic [CW-1:0]    total;

   generate
      if (HI_W > 0) begin : g_ext
         assign div = {pscl_hi_i, pscl_lo_i};
      end else begin : g_noext
         assign div = DIV_W'(pscl_lo_i);
      end
   endgenerate

   assign hard  = fall & bus_idle_i;
   assign total = CW'(ph1_len_i) + CW'(ph2_len_i) + CW'(3);
   assign cfg_err_o = (int'(total) < MIN_TQ) || (int'(total) > MAX_TQ);

   can_rx_sync #(.STAGES(STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .rx    (rx_i),
      .rx_s  (rx_s),
      .fall  (fall)
   );

   can_tq_div #(.DIV_W(DIV_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (hard),
      .div     (div),
      .tq_stb  (tq_stb)
   );

   can_bit_fsm #(
      .TS1_W (TS1_W),
      .TS2_W (TS2_W),
      .SJW_W (SJW_W),
      .CW    (CW)
   ) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .tq_stb  (tq_stb),
      .hard    (hard),
      .fall    (fall),
      .idle    (bus_idle_i),
      .rx_s    (rx_s),
      .ph1_len (ph1_len_i),
      .ph2_len (ph2_len_i),
      .jump_w  (jump_w_i),
      .start_q (bit_start_o),
      .samp_q  (sample_o),
      .rx_bit  (rx_bit_o)
   );

   // R5
   hard_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hard |=> bit_start_o);
   // R2
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bit_start_o && sample_o));
endmodule

// File: tb/sim_can_bit_timer.sv
module sim_can_bit_timer;
   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 190000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] lo = 6'd5;
   logic [3:0] hi = 4'd0;
   logic [3:0] t1 = 4'd4;
   logic [2:0] t2 = 3'd3;
   logic [1:0] sj = 2'd0;
   logic       idle = 1'b0;
   logic       rx = 1'b1;
   logic       bit_start, samp, rx_bit, cfg_err;

   int total = 0;
   int bad   = 0;
   bit ended = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   can_bit_timer u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .pscl_lo_i  (lo),
      .pscl_hi_i  (hi),
      .ph1_len_i  (t1),
      .ph2_len_i  (t2),
      .jump_w_i   (sj),
      .bus_idle_i (idle),
      .rx_i       (rx),
      .bit_start_o(bit_start),
      .sample_o   (samp),
      .rx_bit_o   (rx_bit),
      .cfg_err_o  (cfg_err)
   );

   // per-bit measurement at the falling edge
   int ncyc = 0, t0 = 0, s_off = 0, s_val = 1;
   int b_len = 0, b_soff = 0, b_sval = 1;
   always @(negedge clk) begin
      ncyc = ncyc + 1;
      if (samp) begin
         s_off = ncyc - t0;
         s_val = rx_bit;
      end
      if (bit_start) begin
         b_len  = ncyc - t0;
         b_soff = s_off;
         b_sval = s_val;
         t0     = ncyc;
         s_off  = 0;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_bit();
      do @(negedge clk); while (!bit_start);
      #1;
   endtask

   function automatic int tq();
      return int'({hi, lo}) + 1;
   endfunction

   function automatic int nom();
      return int'(t1) + int'(t2) + 3;
   endfunction

   function automatic int imin(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // one recovery bit (rising edge only), then one bit with a falling edge in quantum k
   task automatic trial(input int k);
      int l1, l2, j, ext, len, q, e, s, sv;
      l1 = int'(t1) + 1;
      l2 = int'(t2) + 1;
      j  = int'(sj) + 1;
      rx = 1'b1;
      wait_bit();
      // R9: the rise at the start of the previous bit changed nothing
      chk("R9 recovery bit length", b_len, nom() * tq());
      chk("R3 recovery sample offset", b_soff, (1 + l1) * tq());
      repeat (k * tq()) @(negedge clk);
      #1 rx = 1'b0;
      ext = 0;
      sv  = 0;
      if (k == 0) begin
         len = nom();
      end else if (k <= l1) begin
         q   = k - 1;
         ext = imin(q + 1, j);
         len = nom() + ext;
      end else begin
         q   = k - 1 - l1;
         e   = l2 - q;
         s   = imin(e, j);
         len = 1 + l1 + imax(q + 1, l2 - s);
         sv  = 1;
      end
      wait_bit();
      if (k == 0)
         chk("R8 sync-slot edge bit length", b_len, len * tq());
      else if (k <= int'(t1) + 1)
         chk("R6 phase1 edge bit length", b_len, len * tq());
      else
         chk("R7 phase2 edge bit length", b_len, len * tq());
      chk("R3 sample offset", b_soff, (1 + l1 + ext) * tq());
      chk("R3 sampled level", b_sval, sv);
   endtask

   initial begin
      int c;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11
      chk("R11 bit_start after reset", int'(bit_start), 0);
      chk("R11 sample after reset", int'(samp), 0);
      chk("R11 rx_bit after reset", int'(rx_bit), 1);

      wait_bit();
      // R4: legality flag
      t1 = 4'd2; t2 = 3'd2; #1 chk("R4 cfg 7 quanta", int'(cfg_err), 1);
      t1 = 4'd3; t2 = 3'd2; #1 chk("R4 cfg 8 quanta", int'(cfg_err), 0);
      t1 = 4'd15; t2 = 3'd7; #1 chk("R4 cfg 25 quanta", int'(cfg_err), 0);
      t1 = 4'd0; t2 = 3'd0; #1 chk("R4 cfg 3 quanta", int'(cfg_err), 1);

      // R1: divider using the extension field, then the smallest divider
      t1 = 4'd3; t2 = 3'd2; hi = 4'd1; lo = 6'd0;
      wait_bit();
      wait_bit();
      chk("R1 extended divider bit length", b_len, 8 * 65);
      hi = 4'd0; lo = 6'd0;
      wait_bit();
      wait_bit();
      chk("R1 unit divider bit length", b_len, 8);
      // R2: nominal length at the sweep divider
      lo = 6'd5; t1 = 4'd6; t2 = 3'd4;
      wait_bit();
      wait_bit();
      chk("R2 nominal bit length", b_len, 13 * 6);

      // R6 R7 R8 sweep
      foreach (t1_set[a]) begin
         foreach (t2_set[b]) begin
            for (int sw = 0; sw < 4; sw++) begin
               t1 = t1_set[a];
               t2 = t2_set[b];
               sj = 2'(sw);
               wait_bit();
               for (int k = 0; k < nom(); k++) trial(k);
            end
         end
      end

      // R10: second falling edge in the same bit is ignored
      t1 = 4'd7; t2 = 3'd3; sj = 2'd3; rx = 1'b1;
      wait_bit();
      wait_bit();
      repeat (tq()) @(negedge clk);
      #1 rx = 1'b0;
      repeat (tq()) @(negedge clk);
      #1 rx = 1'b1;
      repeat (tq()) @(negedge clk);
      #1 rx = 1'b0;
      wait_bit();
      chk("R10 two edges, one adjustment", b_len, (nom() + 1) * tq());

      // R5: hard synchronisation while idle
      rx = 1'b1; idle = 1'b1;
      wait_bit();
      repeat (2 * tq()) @(negedge clk);
      #1 rx = 1'b0;
      c = 0;
      do begin
         @(negedge clk);
         c++;
      end while (!bit_start && c < 50);
      chk("R5 hard sync delay", c, 3);
      #1;
      wait_bit();
      chk("R5 bit after hard sync", b_len, nom() * tq());
      idle = 1'b0; rx = 1'b1;

      if (!ended) begin
         ended = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   logic [3:0] t1_set [3] = '{4'd2, 4'd4, 4'd9};
   logic [2:0] t2_set [3] = '{3'd1, 3'd3, 3'd6};

   initial begin
      #(CLK_PERIOD * WD_CYCLES);
      if (!ended) begin
         ended = 1;
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule